// File: doc/BRIEF.md
# XNOR-Feedback Maximal-Length Pseudo-Random Sequence Generator

This block is a shift-register sequence generator that produces a pseudo-random pattern of configurable width, from 3 to 32 bits. Its feedback bit is the inverted parity (XNOR) of a fixed set of tapped register bits. Each supported width uses a tap set that gives the longest possible cycle. Because the feedback is inverted, a register that is all zeros after reset is a legal running state. The one state that cannot be used is all ones: the register would stay in it for ever.

The surrounding logic resets the generator, or loads it with a start value, and then holds the enable high to advance one state per clock. It reads the current pattern from `value`. A single-cycle `wrap` pulse marks each return to the all-zero start state, so a consumer can count whole periods or line up frames with them. Any seed that would land in the lock-up state is changed to all zeros, so the generator never stops.

Top module: `lfsr_xn_gen`

## Requirements
- R1: The reset `rst` is synchronous and active-high. It overrides every other input. After a clock edge with `rst` high, `value` is all zeros and `wrap` is 0.
- R2: An enabled step (`en`=1, `load`=0, `rst`=0) shifts `value` one place toward the most significant bit. The new bit 0 is the XNOR of the tapped bits, and tap k means bit index k-1. The taps are {3,2} for width 3, {4,3} for 4, {5,3} for 5, {8,6,5,4} for 8 and {16,15,13,4} for 16.
- R3: Starting from all zeros, the generator visits 2^W-1 distinct states and is back at all zeros after exactly 2^W-1 enabled steps. The all-ones pattern never appears on `value`.
- R4: With `en`=0, `load`=0 and `rst`=0, `value` keeps its state across a clock edge.
- R5: With `load`=1 and `rst`=0, the next `value` is `seed`, whatever `en` is.
- R6: A load whose `seed` is all ones puts all zeros into the register.
- R7: `wrap` is 1 for exactly the one clock that follows an enabled step into the all-zero state. It stays 0 after a reset, after a load of zero and after a held cycle.
- R8: The parameter `WIDTH` selects any width from 3 to 32, each with its own maximal-length tap set, and the behaviour above holds at every such width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset to the all-zero state |
| en | input | 1 | Advance the sequence by one state |
| load | input | 1 | Write `seed` into the register; takes priority over `en` |
| seed | input | WIDTH | Start value for a load |
| value | output | WIDTH | Current register contents |
| wrap | output | 1 | One-clock pulse after stepping back into the all-zero state |

## Verification
Some behaviours are checked on every cycle. These are that all ones never shows on `value`, that a held cycle keeps the state, that a load writes `seed` or changes all ones to zero, that every step changes the state, and that `wrap` is a single-cycle pulse seen only with all zeros. The length of the period, the order of the states against the tap rule, and the exact cycle on which `wrap` fires can only be shown by the bench. It walks full periods at width 4 and width 16 against a model built from the tap rule, and it runs a table of mixed reset, hold, step and load cycles.

// File: rtl/lfsr_xn_pkg.sv
package lfsr_xn_pkg;

    localparam int MIN_WIDTH = 3;
    localparam int MAX_WIDTH = 32;

    // Operation applied on a clock edge, in priority order
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } op_e;

    typedef struct packed {
        op_e  op;
        logic seed_locked;   // requested seed equals the lock-up pattern
    } ctrl_t;

    // Tap mask per width: bit (k-1) set for tap k
    function automatic logic [MAX_WIDTH-1:0] tap_mask(input int w);
        logic [MAX_WIDTH-1:0] m;
        m = '0;
        case (w)
            3:  begin m[2] = 1'b1; m[1] = 1'b1; end
            4:  begin m[3] = 1'b1; m[2] = 1'b1; end
            5:  begin m[4] = 1'b1; m[2] = 1'b1; end
            6:  begin m[5] = 1'b1; m[4] = 1'b1; end
            7:  begin m[6] = 1'b1; m[5] = 1'b1; end
            8:  begin m[7] = 1'b1; m[5] = 1'b1; m[4] = 1'b1; m[3] = 1'b1; end
            9:  begin m[8] = 1'b1; m[4] = 1'b1; end
            10: begin m[9] = 1'b1; m[6] = 1'b1; end
            11: begin m[10] = 1'b1; m[8] = 1'b1; end
            12: begin m[11] = 1'b1; m[5] = 1'b1; m[3] = 1'b1; m[0] = 1'b1; end
            13: begin m[12] = 1'b1; m[3] = 1'b1; m[2] = 1'b1; m[0] = 1'b1; end
            14: begin m[13] = 1'b1; m[4] = 1'b1; m[2] = 1'b1; m[0] = 1'b1; end
            15: begin m[14] = 1'b1; m[13] = 1'b1; end
            16: begin m[15] = 1'b1; m[14] = 1'b1; m[12] = 1'b1; m[3] = 1'b1; end
            17: begin m[16] = 1'b1; m[13] = 1'b1; end
            18: begin m[17] = 1'b1; m[10] = 1'b1; end
            19: begin m[18] = 1'b1; m[5] = 1'b1; m[1] = 1'b1; m[0] = 1'b1; end
            20: begin m[19] = 1'b1; m[16] = 1'b1; end
            21: begin m[20] = 1'b1; m[18] = 1'b1; end
            22: begin m[21] = 1'b1; m[20] = 1'b1; end
            23: begin m[22] = 1'b1; m[17] = 1'b1; end
            24: begin m[23] = 1'b1; m[22] = 1'b1; m[21] = 1'b1; m[16] = 1'b1; end
            25: begin m[24] = 1'b1; m[21] = 1'b1; end
            26: begin m[25] = 1'b1; m[5] = 1'b1; m[1] = 1'b1; m[0] = 1'b1; end
            27: begin m[26] = 1'b1; m[4] = 1'b1; m[1] = 1'b1; m[0] = 1'b1; end
            28: begin m[27] = 1'b1; m[24] = 1'b1; end
            29: begin m[28] = 1'b1; m[26] = 1'b1; end
            30: begin m[29] = 1'b1; m[5] = 1'b1; m[3] = 1'b1; m[0] = 1'b1; end
            31: begin m[30] = 1'b1; m[27] = 1'b1; end
            32: begin m[31] = 1'b1; m[21] = 1'b1; m[1] = 1'b1; m[0] = 1'b1; end
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/lfsr_xn_ctrl.sv
module lfsr_xn_ctrl
    import lfsr_xn_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         rst,
    input  logic         en,
    input  logic         load,
    input  logic [W-1:0] seed,
    output ctrl_t        ctrl
);
    always_comb begin
        ctrl.seed_locked = &seed;
        if (rst)       ctrl.op = OP_CLEAR;
        else if (load) ctrl.op = OP_LOAD;
        else if (en)   ctrl.op = OP_STEP;
        else           ctrl.op = OP_HOLD;
    end
endmodule

// File: rtl/lfsr_xn_feedback.sv
module lfsr_xn_feedback
    import lfsr_xn_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    output logic         fb
);
    localparam logic [MAX_WIDTH-1:0] MASK = tap_mask(W);

    logic [W-1:0] tapped;

    for (genvar i = 0; i < W; i++) begin : g_tap
        if (MASK[i]) begin : g_on
            assign tapped[i] = cur[i];
        end else begin : g_off
            assign tapped[i] = 1'b0;
        end
    end

    assign fb = ~(^tapped);
endmodule

// File: rtl/lfsr_xn_core.sv
module lfsr_xn_core
    import lfsr_xn_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  ctrl_t        ctrl,
    input  logic [W-1:0] seed,
    output logic [W-1:0] cur,
    output logic         step_to_zero
);
    logic         fb;
    logic [W-1:0] stepped;
    logic [W-1:0] nxt;

    lfsr_xn_feedback #(.W(W)) fb_i (
        .cur (cur),
        .fb  (fb)
    );

    assign stepped = {cur[W-2:0], fb};

    always_comb begin
        case (ctrl.op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = ctrl.seed_locked ? '0 : seed;
            OP_STEP:  nxt = stepped;
            default:  nxt = cur;
        endcase
    end

    assign step_to_zero = (ctrl.op == OP_STEP) && (stepped == '0);

    always_ff @(posedge clk) begin
        cur <= nxt;
    end
endmodule

// File: rtl/lfsr_xn_wrap.sv
module lfsr_xn_wrap
    import lfsr_xn_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step_to_zero,
    output logic wrap
);
    always_ff @(posedge clk) begin
        if (rst) wrap <= 1'b0;
        else     wrap <= step_to_zero;
    end
endmodule

// File: rtl/lfsr_xn_gen.sv
module lfsr_xn_gen
    import lfsr_xn_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic [WIDTH-1:0] seed,
    output logic [WIDTH-1:0] value,
    output logic             wrap
);
    ctrl_t ctrl;
    logic  step_to_zero;

    lfsr_xn_ctrl #(.W(WIDTH)) ctrl_i (
        .rst  (rst),
        .en   (en),
        .load (load),
        .seed (seed),
        .ctrl (ctrl)
    );

    lfsr_xn_core #(.W(WIDTH)) core_i (
        .clk          (clk),
        .ctrl         (ctrl),
        .seed         (seed),
        .cur          (value),
        .step_to_zero (step_to_zero)
    );

    lfsr_xn_wrap wrap_i (
        .clk          (clk),
        .rst          (rst),
        .step_to_zero (step_to_zero),
        .wrap         (wrap)
    );
endmodule

// File: rtl/lfsr_xn_gen_chk.sv
module lfsr_xn_gen_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic         load,
    input logic [W-1:0] seed,
    input logic [W-1:0] value,
    input logic         wrap
);
    assert_no_lockup_R3: assert property (@(posedge clk) disable iff (rst)
        value != {W{1'b1}});

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!en && !load) |=> $stable(value));

    assert_load_R5: assert property (@(posedge clk) disable iff (rst)
        (load && seed != {W{1'b1}}) |=> value == $past(seed));

    assert_load_ones_R6: assert property (@(posedge clk) disable iff (rst)
        (load && seed == {W{1'b1}}) |=> value == '0);

    assert_step_moves_R2: assert property (@(posedge clk) disable iff (rst)
        (en && !load) |=> value != $past(value));

    assert_wrap_zero_R7: assert property (@(posedge clk) disable iff (rst)
        wrap |-> value == '0);

    assert_wrap_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        wrap |=> !wrap);
endmodule

bind lfsr_xn_gen lfsr_xn_gen_chk #(.W(WIDTH)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .load  (load),
    .seed  (seed),
    .value (value),
    .wrap  (wrap)
);

// File: tb/lfsr_xn_gen_tb_top.sv
module lfsr_xn_gen_tb_top;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int n_checks = 0;
    int n_fail   = 0;

    // Width-4 instance
    logic       rst, en, load;
    logic [3:0] seed;
    logic [3:0] value;
    logic       wrap;

    lfsr_xn_gen #(.WIDTH(4)) dut_i (
        .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed),
        .value(value), .wrap(wrap)
    );

    // Width-16 instance
    logic        rst16, en16, load16;
    logic [15:0] seed16;
    logic [15:0] value16;
    logic        wrap16;

    lfsr_xn_gen #(.WIDTH(16)) dut16_i (
        .clk(clk), .rst(rst16), .en(en16), .load(load16), .seed(seed16),
        .value(value16), .wrap(wrap16)
    );

    // Vector: rst, en, load, seed, expected value, expected wrap, req tag
    typedef struct packed {
        logic       rst;
        logic       en;
        logic       load;
        logic [3:0] seed;
        logic [3:0] exp_val;
        logic       exp_wrap;
        logic [7:0] req;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 1'b0, 4'h0, 4'b0000, 1'b0, 8'd1},  // R1 reset
        '{1'b0, 1'b1, 1'b0, 4'h0, 4'b0001, 1'b0, 8'd2},  // R2 step
        '{1'b0, 1'b1, 1'b0, 4'h0, 4'b0011, 1'b0, 8'd2},
        '{1'b0, 1'b0, 1'b0, 4'h0, 4'b0011, 1'b0, 8'd4},  // R4 hold
        '{1'b0, 1'b1, 1'b0, 4'h0, 4'b0111, 1'b0, 8'd2},
        '{1'b0, 1'b0, 1'b1, 4'hA, 4'b1010, 1'b0, 8'd5},  // R5 load
        '{1'b0, 1'b1, 1'b0, 4'h0, 4'b0100, 1'b0, 8'd2},
        '{1'b0, 1'b1, 1'b0, 4'h0, 4'b1000, 1'b0, 8'd2},
        '{1'b0, 1'b1, 1'b0, 4'h0, 4'b0000, 1'b1, 8'd7},  // R7 wrap
        '{1'b0, 1'b0, 1'b0, 4'h0, 4'b0000, 1'b0, 8'd7},  // R7 clears on hold
        '{1'b0, 1'b0, 1'b1, 4'hF, 4'b0000, 1'b0, 8'd6},  // R6 ones->zero
        '{1'b0, 1'b1, 1'b0, 4'h0, 4'b0001, 1'b0, 8'd6},
        '{1'b0, 1'b1, 1'b1, 4'h8, 4'b1000, 1'b0, 8'd5},  // R5 load beats en
        '{1'b1, 1'b1, 1'b1, 4'h5, 4'b0000, 1'b0, 8'd1},  // R1 reset wins
        '{1'b0, 1'b1, 1'b0, 4'h0, 4'b0001, 1'b0, 8'd2}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref16(input logic [15:0] s);
        return {s[14:0], ~(s[15] ^ s[14] ^ s[12] ^ s[3])};
    endfunction

    initial begin
        #700000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; en = 1'b0; load = 1'b0; seed = '0;
        rst16 = 1'b1; en16 = 1'b0; load16 = 1'b0; seed16 = '0;
        repeat (2) @(posedge clk);

        // Table walk (width 4)
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            rst = VECS[i].rst; en = VECS[i].en; load = VECS[i].load; seed = VECS[i].seed;
            @(posedge clk);
            #1;
            check(value == VECS[i].exp_val, $sformatf("R%0d value vec %0d", VECS[i].req, i),
                  32'(value), 32'(VECS[i].exp_val));
            check(wrap == VECS[i].exp_wrap, $sformatf("R%0d wrap vec %0d", VECS[i].req, i),
                  32'(wrap), 32'(VECS[i].exp_wrap));
        end

        // R3: full width-4 period from zero
        begin
            bit [15:0] seen;
            int wrap_at;
            bit ones_seen;
            seen = '0; wrap_at = -1; ones_seen = 1'b0;
            @(negedge clk); rst = 1'b1; en = 1'b0; load = 1'b0;
            @(negedge clk); rst = 1'b0; en = 1'b1;
            for (int s = 1; s <= 20; s++) begin
                @(posedge clk); #1;
                if (value == 4'hF) ones_seen = 1'b1;
                if (wrap && wrap_at < 0) wrap_at = s;
                if (wrap_at < 0) seen[value] = 1'b1;
            end
            @(negedge clk); en = 1'b0;
            check(wrap_at == 15, "R3 period width 4", 32'(wrap_at), 32'd15);
            check($countones(seen) == 14 && !seen[0], "R3 distinct states width 4",
                  32'($countones(seen)), 32'd14);
            check(!ones_seen, "R3 all-ones absent", 32'(ones_seen), 32'd0);
        end

        // R6 / R7: loading zero gives no wrap pulse
        @(negedge clk); load = 1'b1; seed = 4'h0;
        @(posedge clk); #1;
        check(value == 4'h0 && !wrap, "R7 no wrap on zero load", 32'(wrap), 32'd0);
        @(negedge clk); seed = 4'hF;
        @(posedge clk); #1;
        check(value == 4'h0, "R6 ones seed cleared", 32'(value), 32'd0);
        @(negedge clk); load = 1'b0;

        // R8: width 16 full period against tap-rule model
        begin
            logic [15:0] model;
            int mism, wrap_at, wraps;
            model = '0; mism = 0; wrap_at = -1; wraps = 0;
            @(negedge clk); rst16 = 1'b0; en16 = 1'b1;
            for (int s = 1; s <= 65540; s++) begin
                @(posedge clk); #1;
                model = ref16(model);
                if (value16 != model) mism++;
                if (wrap16) begin
                    wraps++;
                    if (wrap_at < 0) wrap_at = s;
                end
            end
            @(negedge clk); en16 = 1'b0;
            check(mism == 0, "R8 width 16 sequence follows taps", 32'(mism), 32'd0);
            check(wrap_at == 65535, "R8 width 16 period", 32'(wrap_at), 32'd65535);
            check(wraps == 1, "R8 width 16 single wrap", 32'(wraps), 32'd1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule